// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is a per-core down-counter that serves either as a general interval timer or as a watchdog. A simple synchronous register port sets the load value, the prescaler and the control bits. The same port reads back the live count and the status flags. Two outputs leave the block: an interrupt line for interval events and a reset-request pulse meant for the reset controller of the associated CPU.

In interval mode the counter steps down once per prescaled period. When it reaches its terminal count it either stops at zero (single-shot) or reloads (auto-reload). In both cases it raises a sticky event flag, which can drive the interrupt. In watchdog mode software must rewrite the load value before the count runs out. If the count does run out, the block pulses a reset request for a fixed number of cycles and records in a status bit that it did so. Setting the watchdog bit locks the mode in. Only a reset or two key writes in a row release it.

Register map: address 0 is LOAD, address 1 is COUNT (read-only), address 2 is CTRL, address 3 is STAT and address 4 is KEY. The CTRL bits are: bit 0 run, bit 1 auto-reload, bit 2 interrupt enable, bit 3 watchdog mode, and bits 15:8 the prescaler. The STAT bits are: bit 0 the event flag and bit 1 the watchdog-fired flag. Both STAT bits clear when 1 is written to them.

Top module: `wdt_ivt`

## Requirements
- R1: After reset, LOAD, COUNT, CTRL and STAT read 0, and irq and rst_req are low.
- R2: With prescaler value N in CTRL[15:8] and the counter enabled, the count drops by one every N+1 clocks.
- R3: A write to LOAD (address 0) sets the count to the written value at the same edge and restarts the prescale period.
- R4: In single-shot mode (CTRL[1]=0), the tick that takes the count from 1 to 0 sets the event flag STAT[0]. The count then stays at 0.
- R5: In auto-reload mode (CTRL[1]=1, interval mode), the tick that would take the count from 1 to 0 instead reloads the LOAD value and sets STAT[0].
- R6: irq is high exactly when STAT[0]=1, CTRL[2]=1 and watchdog mode is off.
- R7: Writing 1 to STAT[0] clears the event flag. A terminal event in the same cycle wins over the clear.
- R8: In watchdog mode, the tick that takes the count from 1 to 0 raises rst_req for exactly RST_CYCLES clocks (16 by default). It also sets STAT[1] and leaves STAT[0] untouched. Writing 1 to STAT[1] clears that bit.
- R9: In watchdog mode the counter runs whatever the value of CTRL[0], and a LOAD write refreshes it.
- R10: Once CTRL[3] is set, a CTRL write with bit 3 at 0 does not clear it. Watchdog mode ends only when 32'hA5C3_0F01 and then 32'h3C5A_F002 are written to KEY (address 4) on two consecutive KEY writes; any other KEY write breaks the sequence.
- R11: In interval mode with CTRL[0]=0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Read data for rd_addr (combinational) |
| irq | output | 1 | Interval event interrupt |
| rst_req | output | 1 | Watchdog reset request pulse |

## Verification
The bench aims at the terminal edge itself.

- A design that reloads one tick late would read 0 between reload periods.
- One that lets a single-shot count wrap would read all-ones.
- A prescaler off by one shifts every decrement and shows up within the first period.

The watchdog cases check three things. A stray CTRL write or a broken key pair must not drop the mode. The reset pulse must last exactly its length, so a stretch counter that is one long or one short is caught. Raising the interrupt while in watchdog mode would show on irq despite a pending event flag.

// File: rtl/wdt_pkg.sv
// Package: shared register addresses, control/status bit positions and the
// two-word key that releases watchdog mode.
package wdt_pkg;
    localparam logic [2:0] REG_LOAD  = 3'd0;
    localparam logic [2:0] REG_COUNT = 3'd1;
    localparam logic [2:0] REG_CTRL  = 3'd2;
    localparam logic [2:0] REG_STAT  = 3'd3;
    localparam logic [2:0] REG_KEY   = 3'd4;

    localparam int CTRL_RUN     = 0;
    localparam int CTRL_AUTO    = 1;
    localparam int CTRL_IEN     = 2;
    localparam int CTRL_WD      = 3;
    localparam int CTRL_PRE_LSB = 8;

    localparam int STAT_EVT = 0;
    localparam int STAT_WDF = 1;

    localparam logic [31:0] KEY_FIRST  = 32'hA5C3_0F01;
    localparam logic [31:0] KEY_SECOND = 32'h3C5A_F002;
endpackage

// File: rtl/wdt_prescale.sv
// Prescaler: emits one tick every div+1 enabled clocks.
// Assumes: clr restarts the period; while en is low the period is held at zero.
module wdt_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] cnt_q;

    // tick when the period counter has reached the divider value
    assign tick = en && (cnt_q >= div);

    // advance or restart the period counter
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr || !en)      cnt_q <= '0;
        else if (tick)            cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
    end

    // R2: between ticks the period counter steps by exactly one
    a_r2_period_step: assert property (@(posedge clk) disable iff (!rst_n)
        en && !clr && !tick |=> cnt_q == $past(cnt_q) + 1'b1);

    // R11: an idle prescaler sits at the start of its period
    a_r11_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt_q == '0);
endmodule

// File: rtl/wdt_downcnt.sv
// Down-counter: loads on demand, steps down on tick, and flags the tick that
// finishes the count. Assumes: ld has priority over tick; reload is used
// only on the 1 -> terminal step; at zero the counter stays put.
module wdt_downcnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             term
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign count = cnt_q;
    // terminal step: a tick that arrives while the count is one
    assign term  = tick && !ld && (cnt_q == ONE);

    // load, reload or decrement the count
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (ld)                     cnt_q <= ld_data;
        else if (tick && cnt_q != '0) begin
            if (cnt_q == ONE && reload)  cnt_q <= reload_val;
            else                         cnt_q <= cnt_q - ONE;
        end
    end

    // R3: a load takes effect at the next edge
    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt_q == $past(ld_data));

    // R2: a tick above one lowers the count by one
    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !ld && cnt_q > ONE |=> cnt_q == $past(cnt_q) - ONE);

    // R4: zero is sticky without a load
    a_r4_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ld && cnt_q == '0 |=> cnt_q == '0);

    // R11: without tick or load the count does not move
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !ld |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_rststretch.sv
// Reset-request stretcher: a one-cycle fire becomes a request held for
// RST_CYCLES clocks. Assumes: a fire during the pulse restarts the length.
module wdt_rststretch #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic req
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic [RW-1:0] left_q;

    assign req = (left_q != '0);

    // count down the remaining request cycles
    always_ff @(posedge clk) begin
        if (!rst_n)          left_q <= '0;
        else if (fire)       left_q <= RW'(RST_CYCLES);
        else if (left_q != '0) left_q <= left_q - 1'b1;
    end

    // R8: the request starts on the edge after a fire
    a_r8_req_start: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> req);

    // R8: no request appears without a fire
    a_r8_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req && !fire |=> !req);
endmodule

// File: rtl/wdt_ivt.sv
// Dual-mode watchdog / interval timer top. Holds the software-visible
// registers, the watchdog lock and key sequence, and wires the prescaler,
// down-counter and reset stretcher. Assumes: one register write per cycle,
// combinational read, CNT_W >= CTRL_PRE_LSB + PRE_W.
module wdt_ivt
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int PRE_W      = 8,
    parameter int RST_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq,
    output logic             rst_req
);
    logic             run_q, auto_q, ien_q, wd_q, stage_q, evt_q, wdf_q;
    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] count;
    logic             tick, term, fire, cnt_en;
    logic             wr_load, wr_ctrl, wr_stat, wr_key, key_a_hit, key_b_hit;

    // decode the write strobe per register
    always_comb begin
        wr_load   = wr_en && (wr_addr == REG_LOAD);
        wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
        wr_stat   = wr_en && (wr_addr == REG_STAT);
        wr_key    = wr_en && (wr_addr == REG_KEY);
        key_a_hit = wr_key && (wr_data == CNT_W'(KEY_FIRST));
        key_b_hit = wr_key && stage_q && (wr_data == CNT_W'(KEY_SECOND));
    end

    assign cnt_en = run_q || wd_q;
    assign fire   = term && wd_q;
    assign irq    = evt_q && ien_q && !wd_q;

    wdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(wr_load),
        .div(presc_q), .tick(tick)
    );

    wdt_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ld(wr_load), .ld_data(wr_data),
        .tick(tick), .reload(auto_q && !wd_q), .reload_val(load_q),
        .count(count), .term(term)
    );

    wdt_rststretch #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .fire(fire), .req(rst_req)
    );

    // capture the load value
    always_ff @(posedge clk) begin
        if (!rst_n)       load_q <= '0;
        else if (wr_load) load_q <= wr_data;
    end

    // capture the plain control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            auto_q  <= 1'b0;
            ien_q   <= 1'b0;
            presc_q <= '0;
        end else if (wr_ctrl) begin
            run_q   <= wr_data[CTRL_RUN];
            auto_q  <= wr_data[CTRL_AUTO];
            ien_q   <= wr_data[CTRL_IEN];
            presc_q <= wr_data[CTRL_PRE_LSB +: PRE_W];
        end
    end

    // watchdog lock: set by CTRL, released only by the key pair
    always_ff @(posedge clk) begin
        if (!rst_n)                            wd_q <= 1'b0;
        else if (wr_ctrl && wr_data[CTRL_WD])  wd_q <= 1'b1;
        else if (key_b_hit)                    wd_q <= 1'b0;
    end

    // key sequence progress: armed only by a first-key write
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= 1'b0;
        else if (wr_key) stage_q <= key_a_hit;
    end

    // sticky status flags with write-one-to-clear, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
            wdf_q <= 1'b0;
        end else begin
            if (term && !wd_q)                         evt_q <= 1'b1;
            else if (wr_stat && wr_data[STAT_EVT])     evt_q <= 1'b0;
            if (fire)                                  wdf_q <= 1'b1;
            else if (wr_stat && wr_data[STAT_WDF])     wdf_q <= 1'b0;
        end
    end

    // register read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_LOAD:  rd_data = load_q;
            REG_COUNT: rd_data = count;
            REG_CTRL: begin
                rd_data[CTRL_RUN]                  = run_q;
                rd_data[CTRL_AUTO]                 = auto_q;
                rd_data[CTRL_IEN]                  = ien_q;
                rd_data[CTRL_WD]                   = wd_q;
                rd_data[CTRL_PRE_LSB +: PRE_W]     = presc_q;
            end
            REG_STAT: begin
                rd_data[STAT_EVT] = evt_q;
                rd_data[STAT_WDF] = wdf_q;
            end
            default:   rd_data = '0;
        endcase
    end

    // R7: an interval terminal event always leaves the flag set
    a_r7_evt_set: assert property (@(posedge clk) disable iff (!rst_n)
        term && !wd_q |=> evt_q);

    // R8: a watchdog expiry records itself in status
    a_r8_wdf_set: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> wdf_q);

    // R10: leaving watchdog mode needs the second key on the KEY address
    a_r10_exit_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_q) |-> $past(wr_en && wr_addr == REG_KEY
                              && wr_data == CNT_W'(KEY_SECOND)));

    // R10: a CTRL write cannot drop watchdog mode
    a_r10_ctrl_lock: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q && wr_ctrl |=> wd_q);

    // R6: the interrupt stays quiet while the watchdog is armed
    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q |-> !irq);
endmodule

// File: tb/wdt_ivt_tb_top.sv
// Bench: behavioural reference model updated every clock and compared with
// the outputs at every falling edge, plus directed checks per requirement.
module wdt_ivt_tb_top;
    localparam int RSTC = 16;
    localparam logic [31:0] KA = 32'hA5C3_0F01;
    localparam logic [31:0] KB = 32'h3C5A_F002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd1;
    logic [31:0] rd_data;
    logic        irq, rst_req;

    int total = 0;
    int bad = 0;
    bit cmp_on = 0;
    bit done = 0;
    string cur_req = "R1";

    wdt_ivt dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    // reference model state
    logic [31:0] m_load, m_cnt;
    int  m_pre, m_presc, m_rc;
    bit  m_run, m_auto, m_ien, m_wd, m_stage, m_evt, m_wdf;
    bit  e_en, e_tk, e_ld, e_term, e_fire;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_load = 0; m_cnt = 0; m_pre = 0; m_presc = 0; m_rc = 0;
            m_run = 0; m_auto = 0; m_ien = 0; m_wd = 0; m_stage = 0;
            m_evt = 0; m_wdf = 0;
        end else begin
            e_en   = m_run || m_wd;
            e_tk   = e_en && (m_pre >= m_presc);
            e_ld   = wr_en && wr_addr == 3'd0;
            e_term = e_tk && !e_ld && m_cnt == 1;
            e_fire = e_term && m_wd;
            if (e_ld || !e_en || e_tk) m_pre = 0; else m_pre = m_pre + 1;
            if (e_ld) m_cnt = wr_data;
            else if (e_tk && m_cnt != 0) begin
                if (m_cnt == 1 && m_auto && !m_wd) m_cnt = m_load;
                else m_cnt = m_cnt - 1;
            end
            if (e_term && !m_wd) m_evt = 1;
            else if (wr_en && wr_addr == 3'd3 && wr_data[0]) m_evt = 0;
            if (e_fire) m_wdf = 1;
            else if (wr_en && wr_addr == 3'd3 && wr_data[1]) m_wdf = 0;
            if (e_fire) m_rc = RSTC; else if (m_rc > 0) m_rc = m_rc - 1;
            if (e_ld) m_load = wr_data;
            if (wr_en && wr_addr == 3'd2) begin
                m_run = wr_data[0]; m_auto = wr_data[1]; m_ien = wr_data[2];
                m_presc = int'(wr_data[15:8]);
                if (wr_data[3]) m_wd = 1;
            end
            if (wr_en && wr_addr == 3'd4) begin
                if (m_stage && wr_data == KB) m_wd = 0;
                m_stage = (wr_data == KA);
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_load;
            3'd1: return m_cnt;
            3'd2: return {16'd0, 8'(m_presc), 4'd0, m_wd, m_ien, m_auto, m_run};
            3'd3: return {30'd0, m_wdf, m_evt};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(cur_req, "rd_data", rd_data, m_read(rd_addr));
            check(cur_req, "irq", 32'(irq), 32'(m_evt && m_ien && !m_wd));
            check(cur_req, "rst_req", 32'(rst_req), 32'(m_rc != 0));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int hi;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cmp_on = 1;
        // R1 reset state
        cur_req = "R1";
        for (int a = 0; a < 4; a++) begin
            rd(3'(a), d); check("R1", "reset reg", d, 32'd0);
        end
        check("R1", "reset irq", 32'(irq), 32'd0);
        check("R1", "reset rst_req", 32'(rst_req), 32'd0);

        // R11 stopped counter holds
        cur_req = "R11";
        rd_addr = 3'd1;
        wr(3'd0, 32'd10);
        repeat (6) @(posedge clk);
        #2 rd(3'd1, d); check("R11", "held count", d, 32'd10);

        // R2 and R3 prescale 3: one step per 4 clocks after the load
        cur_req = "R2";
        wr(3'd2, 32'h0000_0301);
        wr(3'd0, 32'd10);
        rd(3'd1, d); check("R3", "count after load", d, 32'd10);
        repeat (8) @(posedge clk);
        #2 rd(3'd1, d); check("R2", "count after 8 clocks", d, 32'd8);

        // R4 single shot at prescale 0
        cur_req = "R4";
        wr(3'd2, 32'h0000_0001);
        wr(3'd0, 32'd3);
        repeat (5) @(posedge clk);
        #2 rd(3'd1, d); check("R4", "stopped at zero", d, 32'd0);
        rd(3'd3, d); check("R4", "event flag", d[0], 1'b1);
        check("R6", "irq with enable off", 32'(irq), 32'd0);
        rd_addr = 3'd1;

        // R6 enable irq, R7 clear
        cur_req = "R6";
        wr(3'd2, 32'h0000_0005);
        check("R6", "irq with flag and enable", 32'(irq), 32'd1);
        cur_req = "R7";
        wr(3'd3, 32'd1);
        rd(3'd3, d); check("R7", "flag cleared", d[0], 1'b0);
        check("R7", "irq after clear", 32'(irq), 32'd0);
        rd_addr = 3'd1;

        // R5 auto-reload period 4
        cur_req = "R5";
        wr(3'd2, 32'h0000_0007);
        wr(3'd0, 32'd4);
        repeat (4) @(posedge clk);
        #2 rd(3'd1, d); check("R5", "reloaded count", d, 32'd4);
        rd(3'd3, d); check("R5", "event on reload", d[0], 1'b1);
        rd_addr = 3'd1;
        cur_req = "R7";
        wr(3'd3, 32'd1);
        rd(3'd3, d); check("R7", "flag cleared mid period", d[0], 1'b0);
        rd_addr = 3'd1;
        for (int k = 0; k < 12; k++) wr(3'd3, 32'd1);
        wr(3'd2, 32'h0000_0000);

        // R6 watchdog gates the interrupt
        cur_req = "R6";
        wr(3'd2, 32'h0000_0007);
        wr(3'd0, 32'd2);
        repeat (3) @(posedge clk);
        wr(3'd2, 32'h0000_0004);
        wr(3'd0, 32'd20);
        wr(3'd2, 32'h0000_000C);
        rd(3'd3, d); check("R6", "flag pending in wd", d[0], 1'b1);
        check("R6", "irq masked in wd", 32'(irq), 32'd0);
        rd_addr = 3'd1;

        // R9 refresh keeps the watchdog away from zero
        cur_req = "R9";
        for (int k = 0; k < 5; k++) begin
            repeat (10) @(posedge clk);
            wr(3'd0, 32'd20);
        end
        check("R9", "no reset while refreshed", 32'(rst_req), 32'd0);
        rd(3'd1, d); check("R9", "count refreshed", d, 32'd20);

        // R10 lock against CTRL and broken key pair
        cur_req = "R10";
        wr(3'd2, 32'h0000_0004);
        rd(3'd2, d); check("R10", "wd kept after ctrl write", d[3], 1'b1);
        wr(3'd4, KA); wr(3'd4, 32'h0000_1234); wr(3'd4, KB);
        rd(3'd2, d); check("R10", "wd kept after broken key", d[3], 1'b1);
        rd_addr = 3'd1;
        wr(3'd0, 32'd30);

        // R8 expiry and pulse length
        cur_req = "R8";
        wr(3'd0, 32'd5);
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk); #2;
            if (rst_req) hi++;
        end
        check("R8", "pulse length", 32'(hi), 32'(RSTC));
        rd(3'd3, d); check("R8", "wd flag", d[1], 1'b1);
        check("R8", "event flag untouched", d[0], 1'b1);
        rd_addr = 3'd1;
        wr(3'd3, 32'd2);
        rd(3'd3, d); check("R8", "wd flag cleared", d[1], 1'b0);

        // R10 full key pair releases the mode
        cur_req = "R10";
        wr(3'd4, KA); wr(3'd4, KB);
        rd(3'd2, d); check("R10", "wd released", d[3], 1'b0);
        check("R6", "irq back in interval mode", 32'(irq), 32'd1);
        rd_addr = 3'd1;
        repeat (5) @(posedge clk);
        #1 finish_run();
    end
endmodule